// File: doc/BRIEF.md
# UART Interrupt Identification Controller

This block merges the status conditions of a UART transmitter and receiver into one interrupt request and a 4-bit identification value that the host reads to find out why it was interrupted. It holds the 3-bit interrupt-enable register and resolves the pending sources by fixed priority:

1. line status (receiver errors);
2. receive data available, or receiver time-out;
3. transmit holding empty.

It also contains a receiver idle timer that is active only in FIFO mode. The timer raises a time-out when the receive FIFO holds data but has seen no write or read for four character times. No line-status bit shows this time-out; only the identification code reports it.

The host writes the enable register through `ier_we`/`ier_din`. It reads the identification value on `iir` and signals its register reads with the strobes `rd_iir`, `rd_lsr` and `rd_data`. These strobes acknowledge sources. The serializer, the deserializer, the FIFO storage and the baud generator sit outside the block. They provide:

- the empty and data-ready levels;
- the FIFO level and the trigger threshold;
- single-cycle error and FIFO-write pulses;
- a one-cycle tick per bit time.

The transmit-empty source is tracked by a three-state machine:

| State | Meaning |
|---|---|
| THR_BUSY | holding register occupied |
| THR_PEND | empty and unacknowledged |
| THR_ACKED | empty, acknowledged by an identification read |

Its transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| go_empty | THR_BUSY | THR_PEND | `tx_empty` high |
| refill | THR_PEND | THR_BUSY | `tx_empty` low |
| ack | THR_PEND | THR_ACKED | `rd_iir` while `iir` shows the transmit-empty code |
| reload | THR_ACKED | THR_BUSY | `tx_empty` low |

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is applied, `irq` is 0, `iir` is 4'b0001 and `ier` is 3'b000.
- R2: A cycle with `ier_we` high loads `ier_din` into `ier`, and the new enables already govern the outputs updated at that same edge. Bit 0 of `ier` gates both data-available and time-out, bit 1 gates transmit-empty, and bit 2 gates line status. A source whose enable bit is 0 never drives `irq` or `iir`.
- R3: `iir[0]` is 0 exactly when an enabled source is pending, and `iir[3:1]` then holds its code. The codes are 3'b011 for line status, 3'b010 for data available, 3'b110 for time-out and 3'b001 for transmit empty. Priority is line status, then data available, then time-out, then transmit empty. With nothing pending, `iir` = 4'b0001.
- R4: A pulse on any of `err_overrun`, `err_parity`, `err_framing` or `err_break` sets a line-status pending flag. `rd_lsr` clears it. An error pulse in the same cycle as `rd_lsr` leaves it set.
- R5: The data-available condition depends on the mode. In non-FIFO mode (`fifo_mode`=0) it equals `rx_ready`, and `rx_level` is ignored. In FIFO mode it is `rx_level != 0 && rx_level >= rx_trig`, and `rx_ready` is ignored.
- R6: The time-out (code 3'b110) sets only in FIFO mode with `rx_level != 0`. It sets on the bit tick that completes 4*F ticks without a restart, where F = 7 + `data_len` + `parity_on` + `stop_two` (`data_len` 0..3 selects 5..8 data bits).
- R7: A cycle with `rx_push`, `rd_data`, `rx_level == 0` or `fifo_mode` = 0 clears the time-out and restarts its count from zero.
- R8: While `tx_empty` is high, transmit-empty is pending. A `rd_iir` strobe in a cycle where `iir` = 4'b0010 acknowledges it, and it stays cleared until `tx_empty` has gone low and high again. A `rd_iir` while another code is shown does not acknowledge it.
- R9: `irq` and `iir` are registered and change at the same clock edge as the source state. When the last enabled source clears, `irq` is low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_we | input | 1 | Enable-register write strobe |
| ier_din | input | 3 | Enable-register write data |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single-character mode |
| tx_empty | input | 1 | Transmit holding register / FIFO empty |
| rx_ready | input | 1 | At least one unread received character |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive FIFO trigger threshold |
| rx_push | input | 1 | Receive FIFO write pulse |
| err_overrun | input | 1 | Overrun error pulse |
| err_parity | input | 1 | Parity error pulse |
| err_framing | input | 1 | Framing error pulse |
| err_break | input | 1 | Break detected pulse |
| bit_tick | input | 1 | One pulse per bit time |
| data_len | input | 2 | Data bits minus 5 |
| parity_on | input | 1 | Parity bit present in the frame |
| stop_two | input | 1 | Two stop bits |
| rd_data | input | 1 | Host read of the receive data register |
| rd_iir | input | 1 | Host read of the identification register |
| rd_lsr | input | 1 | Host read of the line-status register |
| irq | output | 1 | Interrupt request |
| iir | output | 4 | Identification value: code in [3:1], no-pending flag in [0] |
| ier | output | 3 | Current enable register |

## Verification
The bench builds the block with `LVL_W` = 3. With that setting every pairing of FIFO level and trigger threshold, 8 levels against 7 thresholds, is swept exhaustively. `CHARS_TO` stays at 4, so the longest time-out window is 48 ticks. That keeps all 16 frame configurations within reach, and each one is counted tick by tick up to its exact firing edge. The 8 enable masks are crossed with the 8 combinations of line-status, data-available and transmit-empty pending. This covers every priority outcome, whose expected code the bench derives arithmetically.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [1:0] {
        THR_BUSY,
        THR_PEND,
        THR_ACKED
    } thr_state_e;

    localparam logic [2:0] CODE_NONE = 3'b000;
    localparam logic [2:0] CODE_THRE = 3'b001;
    localparam logic [2:0] CODE_RDA  = 3'b010;
    localparam logic [2:0] CODE_LS   = 3'b011;
    localparam logic [2:0] CODE_TMO  = 3'b110;

    // start + 5 data + 1 stop; extra data, parity and stop bits are added on top
    localparam int unsigned BASE_FRAME = 7;

    function automatic int unsigned frame_bits(input logic [1:0] dlen,
                                               input logic       par,
                                               input logic       stp2);
        return BASE_FRAME + {30'd0, dlen} + {31'd0, par} + {31'd0, stp2};
    endfunction

endpackage

// File: rtl/uart_rx_idle_timer.sv
module uart_rx_idle_timer
    import uart_irq_pkg::*;
#(
    parameter int LVL_W    = 5,
    parameter int CHARS_TO = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             bit_tick,
    input  logic [1:0]       data_len,
    input  logic             parity_on,
    input  logic             stop_two,
    output logic             tmo_nxt
);

    localparam int MAX_LIM = CHARS_TO * 12;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d, lim;
    logic             tmo_q, tmo_d;

    always_comb begin
        lim = CNT_W'(CHARS_TO * frame_bits(data_len, parity_on, stop_two));
    end

    always_comb begin
        cnt_d = cnt_q;
        tmo_d = tmo_q;
        if (!fifo_mode || (rx_level == '0) || rx_push || rx_pop) begin
            cnt_d = '0;
            tmo_d = 1'b0;
        end else if (bit_tick && !tmo_q) begin
            if (cnt_q >= lim - 1'b1) begin
                cnt_d = '0;
                tmo_d = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tmo_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            tmo_q <= tmo_d;
        end
    end

    assign tmo_nxt = tmo_d;

endmodule

// File: rtl/uart_thre_fsm.sv
module uart_thre_fsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty,
    input  logic ack,
    output logic pend_nxt
);

    thr_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= THR_BUSY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            THR_BUSY:  if (tx_empty)  state_d = THR_PEND;
            THR_PEND:  if (!tx_empty) state_d = THR_BUSY;
                       else if (ack)  state_d = THR_ACKED;
            THR_ACKED: if (!tx_empty) state_d = THR_BUSY;
            default:                  state_d = THR_BUSY;
        endcase
    end

    always_comb begin
        pend_nxt = (state_d == THR_PEND);
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [2:0] en,
    input  logic       ls,
    input  logic       rda,
    input  logic       tmo,
    input  logic       thre,
    output logic [2:0] code,
    output logic       any
);

    always_comb begin
        if (en[2] && ls)        code = CODE_LS;
        else if (en[0] && rda)  code = CODE_RDA;
        else if (en[0] && tmo)  code = CODE_TMO;
        else if (en[1] && thre) code = CODE_THRE;
        else                    code = CODE_NONE;
        any = (code != CODE_NONE);
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int LVL_W    = 5,
    parameter int CHARS_TO = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_we,
    input  logic [2:0]       ier_din,
    input  logic             fifo_mode,
    input  logic             tx_empty,
    input  logic             rx_ready,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             rx_push,
    input  logic             err_overrun,
    input  logic             err_parity,
    input  logic             err_framing,
    input  logic             err_break,
    input  logic             bit_tick,
    input  logic [1:0]       data_len,
    input  logic             parity_on,
    input  logic             stop_two,
    input  logic             rd_data,
    input  logic             rd_iir,
    input  logic             rd_lsr,
    output logic             irq,
    output logic [3:0]       iir,
    output logic [2:0]       ier
);

    logic [2:0] ier_q, ier_d;
    logic       ls_q, ls_d;
    logic [3:0] iir_q;
    logic       irq_q;
    logic       rda_now, tmo_nxt, thre_nxt, thr_ack, any_err;
    logic [2:0] code;
    logic       any;

    always_comb begin
        any_err = err_overrun | err_parity | err_framing | err_break;
        ier_d   = ier_we ? ier_din : ier_q;
        ls_d    = any_err | (ls_q & ~rd_lsr);
        rda_now = fifo_mode ? ((rx_level != '0) && (rx_level >= rx_trig)) : rx_ready;
        thr_ack = rd_iir && (iir_q == {CODE_THRE, 1'b0});
    end

    uart_rx_idle_timer #(
        .LVL_W    (LVL_W),
        .CHARS_TO (CHARS_TO)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (fifo_mode),
        .rx_level  (rx_level),
        .rx_push   (rx_push),
        .rx_pop    (rd_data),
        .bit_tick  (bit_tick),
        .data_len  (data_len),
        .parity_on (parity_on),
        .stop_two  (stop_two),
        .tmo_nxt   (tmo_nxt)
    );

    uart_thre_fsm u_thre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_empty (tx_empty),
        .ack      (thr_ack),
        .pend_nxt (thre_nxt)
    );

    uart_irq_prio u_prio (
        .en   (ier_d),
        .ls   (ls_d),
        .rda  (rda_now),
        .tmo  (tmo_nxt),
        .thre (thre_nxt),
        .code (code),
        .any  (any)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q <= '0;
            ls_q  <= 1'b0;
            iir_q <= {CODE_NONE, 1'b1};
            irq_q <= 1'b0;
        end else begin
            ier_q <= ier_d;
            ls_q  <= ls_d;
            iir_q <= {code, ~any};
            irq_q <= any;
        end
    end

    assign irq = irq_q;
    assign iir = iir_q;
    assign ier = ier_q;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ier_we,
    input logic       fifo_mode,
    input logic       rx_ready,
    input logic       err_overrun,
    input logic       err_parity,
    input logic       err_framing,
    input logic       err_break,
    input logic       rd_iir,
    input logic       rd_lsr,
    input logic       irq,
    input logic [3:0] iir,
    input logic [2:0] ier
);

    logic errs;
    assign errs = err_overrun | err_parity | err_framing | err_break;

    // R3
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iir[0] |-> (iir[3:1] == 3'b000 && !irq));

    // R2
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == 3'b000 && !ier_we) |=> !irq);

    // R4
    ls_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[2] && !ier_we && errs) |=> (iir == 4'b0110 && irq));

    // R4
    ls_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && !errs && iir == 4'b0110) |=> (iir != 4'b0110));

    // R5
    rda_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && rx_ready && ier[0] && !ier[2] && !ier_we) |=> (iir == 4'b0100));

    // R6
    tmo_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |=> (iir != 4'b1100));

    // R8
    thre_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_iir && iir == 4'b0010 && !ier_we) |=> (iir != 4'b0010));

endmodule

bind uart_irq_ident uart_irq_ident_chk u_irq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ier_we      (ier_we),
    .fifo_mode   (fifo_mode),
    .rx_ready    (rx_ready),
    .err_overrun (err_overrun),
    .err_parity  (err_parity),
    .err_framing (err_framing),
    .err_break   (err_break),
    .rd_iir      (rd_iir),
    .rd_lsr      (rd_lsr),
    .irq         (irq),
    .iir         (iir),
    .ier         (ier)
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;

    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ier_we;
    logic [2:0]    ier_din;
    logic          fifo_mode, tx_empty, rx_ready, rx_push;
    logic [LW-1:0] rx_level, rx_trig;
    logic          err_overrun, err_parity, err_framing, err_break;
    logic          bit_tick, parity_on, stop_two;
    logic [1:0]    data_len;
    logic          rd_data, rd_iir, rd_lsr;
    logic          irq;
    logic [3:0]    iir;
    logic [2:0]    ier;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    uart_irq_ident #(.LVL_W(LW), .CHARS_TO(4)) i_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .ier_we(ier_we), .ier_din(ier_din),
        .fifo_mode(fifo_mode), .tx_empty(tx_empty), .rx_ready(rx_ready),
        .rx_level(rx_level), .rx_trig(rx_trig), .rx_push(rx_push),
        .err_overrun(err_overrun), .err_parity(err_parity),
        .err_framing(err_framing), .err_break(err_break),
        .bit_tick(bit_tick), .data_len(data_len), .parity_on(parity_on),
        .stop_two(stop_two), .rd_data(rd_data), .rd_iir(rd_iir),
        .rd_lsr(rd_lsr), .irq(irq), .iir(iir), .ier(ier)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock; strobes are dropped after it
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        ier_we = 0; rx_push = 0; bit_tick = 0; rd_data = 0; rd_iir = 0; rd_lsr = 0;
        err_overrun = 0; err_parity = 0; err_framing = 0; err_break = 0;
    endtask

    task automatic quiesce();
        fifo_mode = 0; rx_ready = 0; tx_empty = 0; rx_level = 0; rd_lsr = 1;
        cyc();
    endtask

    task automatic set_ier(input logic [2:0] v);
        ier_we = 1; ier_din = v;
    endtask

    function automatic logic [3:0] exp_iir(input logic [2:0] e, input logic ls,
                                           input logic rda, input logic th);
        if (e[2] && ls)  return 4'b0110;
        if (e[0] && rda) return 4'b0100;
        if (e[1] && th)  return 4'b0010;
        return 4'b0001;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; ier_we = 0; ier_din = 0; fifo_mode = 0; tx_empty = 0; rx_ready = 0;
        rx_level = 0; rx_trig = 1; rx_push = 0; err_overrun = 0; err_parity = 0;
        err_framing = 0; err_break = 0; bit_tick = 0; data_len = 0; parity_on = 0;
        stop_two = 0; rd_data = 0; rd_iir = 0; rd_lsr = 0;
        repeat (3) cyc();
        chk("R1 irq", irq, 0);
        chk("R1 iir", iir, 4'b0001);
        chk("R1 ier", ier, 0);
        rst_n = 1;
        cyc();

        // priority sweep: every enable mask against every source mix
        for (int e = 0; e < 8; e++) begin
            for (int m = 0; m < 8; m++) begin
                logic [3:0] x;
                quiesce();
                set_ier(3'(e));
                rx_ready = m[1]; tx_empty = m[0]; err_parity = m[2];
                cyc();
                x = exp_iir(3'(e), m[2], m[1], m[0]);
                chk("R3 code", iir, x);
                chk("R2 irq", irq, x != 4'b0001);
                chk("R2 ier", ier, e);
            end
        end

        // R4: each error kind, clear by status read
        for (int k = 0; k < 4; k++) begin
            quiesce();
            set_ier(3'b100);
            cyc();
            case (k)
                0: err_overrun = 1;
                1: err_parity  = 1;
                2: err_framing = 1;
                default: err_break = 1;
            endcase
            cyc();
            chk("R4 set", iir, 4'b0110);
            rd_lsr = 1;
            cyc();
            chk("R4 clear", iir, 4'b0001);
            chk("R9 irq low", irq, 0);
        end
        err_framing = 1; rd_lsr = 1;
        cyc();
        chk("R4 set wins", iir, 4'b0110);

        // R5: FIFO trigger sweep
        quiesce();
        set_ier(3'b001);
        fifo_mode = 1; rx_ready = 1;
        for (int lv = 0; lv < 8; lv++) begin
            for (int tg = 1; tg < 8; tg++) begin
                rx_level = LW'(lv); rx_trig = LW'(tg);
                cyc();
                chk("R5 fifo", iir, (lv != 0 && lv >= tg) ? 4'b0100 : 4'b0001);
            end
        end
        fifo_mode = 0; rx_ready = 0; rx_level = 7; rx_trig = 1;
        cyc();
        chk("R5 level ignored", iir, 4'b0001);
        rx_ready = 1;
        cyc();
        chk("R5 plain", iir, 4'b0100);
        rx_ready = 0;
        cyc();
        chk("R9 drop", irq, 0);

        // R6: time-out for every frame format
        for (int c = 0; c < 16; c++) begin
            int lim;
            data_len = c[1:0]; parity_on = c[2]; stop_two = c[3];
            lim = 4 * (7 + c[1:0] + c[2] + c[3]);
            quiesce();
            set_ier(3'b001);
            fifo_mode = 1; rx_level = 1; rx_trig = 4; rx_push = 1;
            cyc();
            for (int t = 0; t < lim - 1; t++) begin bit_tick = 1; cyc(); end
            chk("R6 early", irq, 0);
            bit_tick = 1;
            cyc();
            chk("R6 fire", iir, 4'b1100);
            rd_data = 1;
            cyc();
            chk("R7 read clears", iir, 4'b0001);
        end

        // R7: restart on push; R6 gating (limit 48 with data_len=3, parity, 2 stops)
        quiesce();
        fifo_mode = 1; rx_level = 1; rx_push = 1;
        cyc();
        for (int t = 0; t < 40; t++) begin bit_tick = 1; cyc(); end
        rx_push = 1;
        cyc();
        for (int t = 0; t < 40; t++) begin bit_tick = 1; cyc(); end
        chk("R7 push restart", iir, 4'b0001);
        for (int t = 0; t < 8; t++) begin bit_tick = 1; cyc(); end
        chk("R7 fire after restart", iir, 4'b1100);
        quiesce();
        fifo_mode = 1; rx_level = 0;
        for (int t = 0; t < 60; t++) begin bit_tick = 1; cyc(); end
        chk("R6 empty fifo", iir, 4'b0001);
        fifo_mode = 0; rx_level = 1;
        for (int t = 0; t < 60; t++) begin bit_tick = 1; cyc(); end
        chk("R6 non-fifo", iir, 4'b0001);
        quiesce();
        set_ier(3'b000);
        fifo_mode = 1; rx_level = 1; rx_push = 1;
        cyc();
        for (int t = 0; t < 48; t++) begin bit_tick = 1; cyc(); end
        chk("R2 masked timeout", irq, 0);
        set_ier(3'b001);
        cyc();
        chk("R2 shared enable", iir, 4'b1100);

        // R8: transmit-empty acknowledge
        quiesce();
        set_ier(3'b010);
        tx_empty = 1;
        cyc();
        chk("R8 pend", iir, 4'b0010);
        rd_iir = 1;
        cyc();
        chk("R8 ack", iir, 4'b0001);
        chk("R9 ack irq", irq, 0);
        repeat (3) cyc();
        chk("R8 stays acked", iir, 4'b0001);
        tx_empty = 0;
        cyc();
        chk("R8 refilled", iir, 4'b0001);
        tx_empty = 1;
        cyc();
        chk("R8 re-arm", iir, 4'b0010);
        quiesce();
        set_ier(3'b110);
        tx_empty = 1; err_break = 1;
        cyc();
        chk("R8 masked by ls", iir, 4'b0110);
        rd_iir = 1;
        cyc();
        chk("R8 no ack", iir, 4'b0110);
        rd_lsr = 1;
        cyc();
        chk("R8 still pending", iir, 4'b0010);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule